// File: doc/BRIEF.md
# Watchdog timer with keyed service sequence

This block is a watchdog with a 16-bit register interface. A slow tick strobe arrives once per half-second, derived elsewhere from a 32 kHz source. Once software sets the enable bit, a down-counter is loaded from an 8-bit timeout field. The counter loses one step on every tick. If software fails to service it in time, the block issues a reset. Servicing takes two writes to the service register, 0x5555 and then 0xAAAA. Only that pair reloads the counter.

A timeout can produce a single-cycle internal reset pulse or a single-cycle low pulse on the active-low external reset line, depending on a routing bit. A pre-timeout status bit sets a programmable number of half-seconds before expiry. It drives the interrupt output when enabled and is cleared by writing 1. Software can request an internal reset pulse through the control register and can hold the external line low.

Two further registers complete the block:
- A reset-cause register keeps a timeout flag across the system reset. Only the power-on reset clears it.
- A power-down counter runs from system reset. When it expires it pulses the external line once, unless software switches it off first.

Top module: `wdg_timer`

## Requirements
- R1: After reset the register reads are: control 0x0030, interrupt control 0x0000, reset cause 0x0000, power-down 0x0001. The internal reset output is low, the external reset line is high and the interrupt output is low.
- R2: The control register is at offset 0x0. Bits 15:8 hold the timeout value N. Bit 2 is enable. With N programmed and the counter freshly loaded, the (N+1)-th tick produces a one-cycle high pulse on the internal reset output when routing bit 3 is 0. The external line stays high.
- R3: The service register is at offset 0x2. Writing 0x5555 and then 0xAAAA reloads the counter from the timeout field, one cycle after the second write. Any other value written after 0x5555 abandons the pair. A repeated 0x5555 keeps the first step armed.
- R4: Once enable (bit 2) is 1, writing it as 0 leaves it at 1 and counting goes on. The timeout field stays writable and applies at the next reload.
- R5: Suspend (control bit 0) takes its value from the first control write after reset only. When it is 1, ticks that arrive while the low-power input is high do not change the count.
- R6: The interrupt control register is at offset 0x6. Bit 15 is interrupt enable, bit 14 is status, and bits 7:0 are the pre-timeout value P. The status bit sets on a tick that brings the count from P+1 to P. The interrupt output equals status AND enable. Writing 1 to bit 14 clears the status bit.
- R7: With routing bit 3 set, a timeout drives the external reset line low for one cycle instead of pulsing the internal reset.
- R8: A control write with bit 4 at 0 gives a one-cycle internal reset pulse, and bit 4 reads back as 1. While stored control bit 5 is 0, the external reset line is held low.
- R9: The reset-cause register is at offset 0x4. Bit 1 reads 1 after a watchdog timeout. It survives the system reset, is cleared by a software reset request, and is cleared by the power-on reset.
- R10: The power-down register is at offset 0x8, with bit 0 as its enable. After reset the power-down counter pulses the external line low for one cycle on the PD_LIMIT-th tick, and does so only once. Writing 0 to the register beforehand suppresses the pulse.
- R11: When a service reload and a tick fall in the same cycle, the reload wins and the tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| por_n | input | 1 | Power-on reset, active low, clears the reset cause |
| rst_n | input | 1 | System reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle of bus_rd |
| tick_hs | input | 1 | Half-second tick enable, one cycle wide |
| low_pwr | input | 1 | Low-power state indication |
| irq | output | 1 | Pre-timeout interrupt |
| int_rst | output | 1 | Internal reset pulse, active high |
| ext_rst_n | output | 1 | External reset line, active low |

## Verification
A service reload and a counting tick can land in the same cycle. The reload is registered one cycle after the 0xAAAA write, so the bench places a tick exactly in the cycle after that write. It then counts how many further ticks pass before the internal reset pulse. If the tick had been taken, the pulse would come one tick early. The pre-timeout status set and its write-1 clear are exercised in separate cycles. Their ordering is judged through the interrupt output and a read of the interrupt control register.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam int BUS_W = 16;
    localparam int TO_W  = 8;

    // byte offsets
    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_KICK  = 8'h02;
    localparam logic [7:0] OFS_CAUSE = 8'h04;
    localparam logic [7:0] OFS_IRQ   = 8'h06;
    localparam logic [7:0] OFS_PWRDN = 8'h08;

    localparam logic [BUS_W-1:0] KEY_ARM  = 16'h5555;
    localparam logic [BUS_W-1:0] KEY_FIRE = 16'hAAAA;

    // control bit positions
    localparam int CB_EXTSUP = 5;
    localparam int CB_SWSUP  = 4;
    localparam int CB_ROUTE  = 3;
    localparam int CB_EN     = 2;
    localparam int CB_SUSP   = 0;
    // interrupt control bit positions
    localparam int IB_IE  = 15;
    localparam int IB_STS = 14;

    typedef struct packed {
        logic [TO_W-1:0] toval;
        logic            ext_sup;
        logic            route;
        logic            en;
        logic            susp;
        logic            susp_lk;
        logic            ie;
        logic            sts;
        logic [TO_W-1:0] pre;
        logic            pd_en;
        logic            int_rst;
        logic            ext_to;
    } wdg_regs_t;
endpackage

// File: rtl/wdg_svc_seq.sv
module wdg_svc_seq
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [BUS_W-1:0] wdata,
    output logic             kick
);
    typedef struct packed {
        logic armed;
        logic kick;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.kick = 1'b0;
        if (wr) begin
            if (wdata == KEY_ARM) begin
                s_d.armed = 1'b1;
            end else begin
                s_d.kick  = s_q.armed && (wdata == KEY_FIRE);
                s_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign kick = s_q.kick;

    // R3
    kick_after_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.kick |-> $past(s_q.armed));
endmodule

// File: rtl/wdg_down_cnt.sv
module wdg_down_cnt #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          reload,
    input  logic [CW-1:0] reload_val,
    input  logic [CW-1:0] pre,
    output logic          expire,
    output logic          pre_hit
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d   = cnt_q;
        expire  = 1'b0;
        pre_hit = 1'b0;
        if (reload) begin
            cnt_d = reload_val;
        end else if (step) begin
            if (cnt_q == '0) begin
                expire = 1'b1;
                cnt_d  = reload_val;
            end else begin
                cnt_d   = cnt_q - 1'b1;
                pre_hit = ((cnt_q - 1'b1) == pre);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R5
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !reload) |=> $stable(cnt_q));

    // R11
    reload_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (cnt_q == $past(reload_val)));
endmodule

// File: rtl/wdg_pd_cnt.sv
module wdg_pd_cnt #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic arm,
    output logic pulse
);
    localparam int PW = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
        logic          done;
        logic          pulse;
    } pd_t;

    pd_t p_d, p_q;

    always_comb begin
        p_d       = p_q;
        p_d.pulse = 1'b0;
        if (tick && arm && !p_q.done) begin
            if (p_q.cnt == PW'(LIMIT - 1)) begin
                p_d.done  = 1'b1;
                p_d.pulse = 1'b1;
            end else begin
                p_d.cnt = p_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign pulse = p_q.pulse;

    // R10
    pd_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        p_q.pulse |=> !p_q.pulse);

    // R10
    pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> !p_q.pulse);
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
    import wdg_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int PD_LIMIT = 64
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              tick_hs,
    input  logic              low_pwr,
    output logic              irq,
    output logic              int_rst,
    output logic              ext_rst_n
);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_KICK  = ADDR_W'(OFS_KICK);
    localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(OFS_CAUSE);
    localparam logic [ADDR_W-1:0] A_IRQ   = ADDR_W'(OFS_IRQ);
    localparam logic [ADDR_W-1:0] A_PWRDN = ADDR_W'(OFS_PWRDN);

    wdg_regs_t r_d, r_q;
    logic cause_d, cause_q;

    logic wr_ctrl, wr_kick, wr_irq, wr_pwrdn;
    logic start, step, reload, kick, expire, pre_hit, pd_pulse, sw_req;
    logic [TO_W-1:0] reload_val;

    assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
    assign wr_kick  = bus_wr && (bus_addr == A_KICK);
    assign wr_irq   = bus_wr && (bus_addr == A_IRQ);
    assign wr_pwrdn = bus_wr && (bus_addr == A_PWRDN);

    assign start      = wr_ctrl && !r_q.en && bus_wdata[CB_EN];
    assign sw_req     = wr_ctrl && !bus_wdata[CB_SWSUP];
    assign step       = tick_hs && r_q.en && !(r_q.susp && low_pwr);
    assign reload     = start || kick;
    assign reload_val = start ? bus_wdata[15:8] : r_q.toval;

    wdg_svc_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_kick),
        .wdata (bus_wdata),
        .kick  (kick)
    );

    wdg_down_cnt #(.CW(TO_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .reload     (reload),
        .reload_val (reload_val),
        .pre        (r_q.pre),
        .expire     (expire),
        .pre_hit    (pre_hit)
    );

    wdg_pd_cnt #(.LIMIT(PD_LIMIT)) u_pd (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_hs),
        .arm   (r_q.pd_en),
        .pulse (pd_pulse)
    );

    always_comb begin
        r_d         = r_q;
        r_d.int_rst = sw_req;
        r_d.ext_to  = 1'b0;
        if (wr_ctrl) begin
            r_d.toval   = bus_wdata[15:8];
            r_d.ext_sup = bus_wdata[CB_EXTSUP];
            r_d.route   = bus_wdata[CB_ROUTE];
            r_d.en      = r_q.en | bus_wdata[CB_EN];
            if (!r_q.susp_lk) begin
                r_d.susp    = bus_wdata[CB_SUSP];
                r_d.susp_lk = 1'b1;
            end
        end
        if (expire) begin
            if (r_q.route) r_d.ext_to  = 1'b1;
            else           r_d.int_rst = 1'b1;
        end
        if (wr_irq) begin
            r_d.ie  = bus_wdata[IB_IE];
            r_d.pre = bus_wdata[TO_W-1:0];
            if (bus_wdata[IB_STS]) r_d.sts = 1'b0;
        end
        if (pre_hit) r_d.sts = 1'b1;
        if (wr_pwrdn) r_d.pd_en = r_q.pd_en & bus_wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.ext_sup <= 1'b1;
            r_q.pd_en   <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    // reset cause lives on the power-on reset only
    always_comb begin
        cause_d = cause_q;
        if (sw_req) cause_d = 1'b0;
        if (expire) cause_d = 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cause_q <= 1'b0;
        else        cause_q <= cause_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                A_CTRL:  bus_rdata = {r_q.toval, 2'b00, r_q.ext_sup, 1'b1,
                                      r_q.route, r_q.en, 1'b0, r_q.susp};
                A_CAUSE: bus_rdata = {14'd0, cause_q, 1'b0};
                A_IRQ:   bus_rdata = {r_q.ie, r_q.sts, 6'd0, r_q.pre};
                A_PWRDN: bus_rdata = {15'd0, r_q.pd_en};
                default: bus_rdata = '0;
            endcase
        end
    end

    assign irq       = r_q.sts & r_q.ie;
    assign int_rst   = r_q.int_rst;
    assign ext_rst_n = !(r_q.ext_to || pd_pulse || !r_q.ext_sup);

    // R4
    en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.en |=> r_q.en);

    // R5
    susp_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.susp_lk |=> $stable(r_q.susp));

    // R6
    sts_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.sts) |-> $past(pre_hit));

    // R7
    route_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && r_q.route) |=> !ext_rst_n);

    // R8
    sw_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_req |=> int_rst);
endmodule

// File: tb/wdg_timer_test.sv
module wdg_timer_test;
    localparam int PDL = 6;
    localparam logic [3:0] A_CTRL = 4'h0, A_KICK = 4'h2, A_CAUSE = 4'h4,
                           A_IRQ = 4'h6, A_PWRDN = 4'h8;
    localparam int S_RD = 0, S_INT = 1, S_EXT = 2, S_IRQ = 3;

    logic        clk = 1'b0;
    logic        por_n = 1'b0, rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        tick_hs = 1'b0, low_pwr = 1'b0;
    logic        irq, int_rst, ext_rst_n;

    always #5 clk = ~clk;

    wdg_timer #(.ADDR_W(4), .PD_LIMIT(PDL)) uut (
        .clk (clk), .por_n (por_n), .rst_n (rst_n),
        .bus_wr (bus_wr), .bus_rd (bus_rd), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .tick_hs (tick_hs), .low_pwr (low_pwr),
        .irq (irq), .int_rst (int_rst), .ext_rst_n (ext_rst_n)
    );

    int total = 0, bad = 0, dn = 0, nn = 0;
    bit started = 0, finished = 0;
    logic lp_v = 1'b0, rstn_v = 1'b1, por_v = 1'b1;

    // scoreboard queues
    int          q_due[$];
    int          q_sel[$];
    logic [15:0] q_exp[$];
    string       q_tag[$];

    task automatic drive(input logic w, input logic r, input logic [3:0] a,
                         input logic [15:0] d, input logic t);
        @(posedge clk);
        #1;
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; tick_hs = t;
        low_pwr = lp_v; rst_n = rstn_v; por_n = por_v;
        started = 1;
        dn++;
    endtask

    task automatic expect_item(input int sel, input int lag, input logic [15:0] e,
                               input string tag);
        q_due.push_back(dn + lag);
        q_sel.push_back(sel);
        q_exp.push_back(e);
        q_tag.push_back(tag);
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [15:0] d);
        drive(1'b1, 1'b0, a, d, 1'b0);
    endtask

    task automatic rd_reg(input logic [3:0] a, input logic [15:0] e, input string tag);
        drive(1'b0, 1'b1, a, 16'h0, 1'b0);
        expect_item(S_RD, 0, e, tag);
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 4'h0, 16'h0, 1'b0);
    endtask

    task automatic tk(input int sel, input logic e, input string tag);
        drive(1'b0, 1'b0, 4'h0, 16'h0, 1'b1);
        expect_item(sel, 1, {15'd0, e}, tag);
    endtask

    task automatic service();
        wr_reg(A_KICK, 16'h5555);
        wr_reg(A_KICK, 16'hAAAA);
        idle();
    endtask

    // monitor
    always @(negedge clk) begin
        if (started) begin
            nn++;
            for (int i = q_due.size() - 1; i >= 0; i--) begin
                if (q_due[i] == nn) begin
                    logic [15:0] act;
                    case (q_sel[i])
                        S_RD:    act = bus_rdata;
                        S_INT:   act = {15'd0, int_rst};
                        S_EXT:   act = {15'd0, ext_rst_n};
                        default: act = {15'd0, irq};
                    endcase
                    total++;
                    if (act !== q_exp[i]) begin
                        bad++;
                        $display("FAIL %s: actual=%h expected=%h (cycle %0d)",
                                 q_tag[i], act, q_exp[i], nn);
                    end
                    q_due.delete(i); q_sel.delete(i); q_exp.delete(i); q_tag.delete(i);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);

        // R1 reset values
        rd_reg(A_CTRL, 16'h0030, "R1 ctrl");
        expect_item(S_INT, 0, 16'h0, "R1 int_rst");
        expect_item(S_EXT, 0, 16'h1, "R1 ext_rst_n");
        expect_item(S_IRQ, 0, 16'h0, "R1 irq");
        rd_reg(A_PWRDN, 16'h0001, "R1 pwrdn");
        rd_reg(A_CAUSE, 16'h0000, "R1 cause");
        rd_reg(A_IRQ, 16'h0000, "R1 irqctl");

        // R10 power-down pulse on the PDL-th tick, once
        for (int i = 1; i < PDL; i++) tk(S_EXT, 1'b1, "R10 before limit");
        tk(S_EXT, 1'b0, "R10 pulse");
        idle(); expect_item(S_EXT, 1, 16'h1, "R10 pulse ends");
        for (int i = 0; i < 3; i++) tk(S_EXT, 1'b1, "R10 only once");

        // R2 period N+1 with N=3
        wr_reg(A_CTRL, 16'h0334);
        rd_reg(A_CTRL, 16'h0334, "R2 ctrl readback");
        for (int i = 0; i < 3; i++) tk(S_INT, 1'b0, "R2 before expiry");
        tk(S_INT, 1'b1, "R2 expiry pulse");
        expect_item(S_EXT, 1, 16'h1, "R2 ext stays high");
        idle(); expect_item(S_INT, 1, 16'h0, "R2 single cycle");
        rd_reg(A_CAUSE, 16'h0002, "R9 cause set");

        // R3 good pair reloads
        tk(S_INT, 1'b0, "R3 pre"); tk(S_INT, 1'b0, "R3 pre");
        service();
        for (int i = 0; i < 3; i++) tk(S_INT, 1'b0, "R3 reloaded");
        tk(S_INT, 1'b1, "R3 expiry after reload");
        // R3 broken pair does not reload
        tk(S_INT, 1'b0, "R3 pre"); tk(S_INT, 1'b0, "R3 pre");
        wr_reg(A_KICK, 16'h5555); wr_reg(A_KICK, 16'h1234); wr_reg(A_KICK, 16'hAAAA);
        idle();
        tk(S_INT, 1'b0, "R3 no reload");
        tk(S_INT, 1'b1, "R3 broken pair expiry");
        // R3 repeated arm key
        tk(S_INT, 1'b0, "R3 pre");
        wr_reg(A_KICK, 16'h5555); wr_reg(A_KICK, 16'h5555); wr_reg(A_KICK, 16'hAAAA);
        idle();
        for (int i = 0; i < 3; i++) tk(S_INT, 1'b0, "R3 rearm reload");
        tk(S_INT, 1'b1, "R3 rearm expiry");

        // R11 reload and tick in the same cycle
        tk(S_INT, 1'b0, "R11 pre"); tk(S_INT, 1'b0, "R11 pre");
        wr_reg(A_KICK, 16'h5555); wr_reg(A_KICK, 16'hAAAA);
        tk(S_INT, 1'b0, "R11 tick dropped");
        for (int i = 0; i < 3; i++) tk(S_INT, 1'b0, "R11 full period");
        tk(S_INT, 1'b1, "R11 expiry");

        // R4 enable sticks, timeout field writable
        wr_reg(A_CTRL, 16'h0330);
        rd_reg(A_CTRL, 16'h0334, "R4 enable kept");
        for (int i = 0; i < 3; i++) tk(S_INT, 1'b0, "R4 counting");
        tk(S_INT, 1'b1, "R4 still expires");
        wr_reg(A_CTRL, 16'h0134);
        rd_reg(A_CTRL, 16'h0134, "R4 new timeout");
        service();
        tk(S_INT, 1'b0, "R4 short period");
        tk(S_INT, 1'b1, "R4 short expiry");

        // R6 pre-timeout
        wr_reg(A_CTRL, 16'h0334);
        wr_reg(A_IRQ, 16'hC001);
        expect_item(S_IRQ, 1, 16'h0, "R6 cleared");
        service();
        tk(S_IRQ, 1'b0, "R6 not yet");
        tk(S_IRQ, 1'b1, "R6 status sets");
        rd_reg(A_IRQ, 16'hC001, "R6 status read");
        wr_reg(A_IRQ, 16'hC001);
        expect_item(S_IRQ, 1, 16'h0, "R6 w1c");
        rd_reg(A_IRQ, 16'h8001, "R6 after w1c");
        tk(S_IRQ, 1'b0, "R6 no rehit");
        tk(S_INT, 1'b1, "R6 expiry");
        wr_reg(A_IRQ, 16'h0001);
        tk(S_IRQ, 1'b0, "R6 masked");
        tk(S_IRQ, 1'b0, "R6 masked hit");
        rd_reg(A_IRQ, 16'h4001, "R6 masked status");
        wr_reg(A_IRQ, 16'h4001);
        rd_reg(A_IRQ, 16'h0001, "R6 masked w1c");
        tk(S_INT, 1'b0, "R6 count");
        tk(S_INT, 1'b1, "R6 expiry 2");

        // R7 routing to external line
        wr_reg(A_CTRL, 16'h033C);
        for (int i = 0; i < 3; i++) tk(S_EXT, 1'b1, "R7 before expiry");
        tk(S_EXT, 1'b0, "R7 ext pulse");
        expect_item(S_INT, 1, 16'h0, "R7 no internal pulse");
        idle(); expect_item(S_EXT, 1, 16'h1, "R7 ext released");

        // R8 software reset and external hold
        wr_reg(A_CTRL, 16'h032C);
        expect_item(S_INT, 1, 16'h1, "R8 sw reset pulse");
        idle(); expect_item(S_INT, 1, 16'h0, "R8 pulse ends");
        rd_reg(A_CAUSE, 16'h0000, "R9 cleared by sw reset");
        wr_reg(A_CTRL, 16'h031C);
        expect_item(S_EXT, 1, 16'h0, "R8 ext held");
        idle(); expect_item(S_EXT, 1, 16'h0, "R8 ext still held");
        rd_reg(A_CTRL, 16'h031C, "R8 readback");
        wr_reg(A_CTRL, 16'h033C);
        expect_item(S_EXT, 1, 16'h1, "R8 ext released");

        // R9 cause survives system reset
        for (int i = 0; i < 3; i++) tk(S_EXT, 1'b1, "R9 counting");
        tk(S_EXT, 1'b0, "R9 expiry");
        rd_reg(A_CAUSE, 16'h0002, "R9 cause set");
        rstn_v = 1'b0; idle(); idle();
        rstn_v = 1'b1; idle();
        rd_reg(A_CAUSE, 16'h0002, "R9 survives rst_n");
        rd_reg(A_CTRL, 16'h0030, "R9 ctrl reset");
        por_v = 1'b0; idle();
        por_v = 1'b1; idle();
        rd_reg(A_CAUSE, 16'h0000, "R9 cleared by por_n");

        // R10 disabled power-down counter
        wr_reg(A_PWRDN, 16'h0000);
        rd_reg(A_PWRDN, 16'h0000, "R10 disabled");
        for (int i = 0; i < PDL + 1; i++) tk(S_EXT, 1'b1, "R10 suppressed");

        // R5 suspend write-once and pause
        wr_reg(A_CTRL, 16'h0235);
        wr_reg(A_CTRL, 16'h0234);
        rd_reg(A_CTRL, 16'h0235, "R5 suspend locked");
        lp_v = 1'b1;
        for (int i = 0; i < 5; i++) tk(S_INT, 1'b0, "R5 paused");
        lp_v = 1'b0;
        tk(S_INT, 1'b0, "R5 resume"); tk(S_INT, 1'b0, "R5 resume");
        tk(S_INT, 1'b1, "R5 expiry");

        repeat (3) idle();
        if (q_due.size() != 0) begin
            total++; bad++;
            $display("FAIL scoreboard: actual=%0d pending expected=0", q_due.size());
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule